// File: doc/BRIEF.md
# Tiny 16-bit Register-Machine Core

A small multi-cycle processor core with three 16-bit general registers. After a start pulse it clears its registers and program counter, then fetches 16-bit instruction words from an external instruction-memory read port and executes them one at a time. The instruction set is load-immediate, add, a three-step register rotate, a backward branch and halt. Execution ends on halt, which copies register 0 to the result output, or on a fault (undefined opcode or an out-of-range register index), which raises a sticky error flag.

The memory port has registered-read timing: the core drives an address in one cycle and samples the returned word in the next. There is no data memory and nothing writes instruction memory. The controller is a single enumerated state machine with these states: `ST_IDLE` (after reset), `ST_FETCH` (address on the port), `ST_LATCH` (word captured into the instruction register), `ST_EXEC` (decode and first write), `ST_ROT2` and `ST_ROT3` (the second and third steps of a rotate), `ST_DONE` (halted normally) and `ST_FAULT` (halted with error). The transitions are as follows. IDLE, DONE and FAULT go to FETCH on start. FETCH goes to LATCH, and LATCH goes to EXEC. EXEC goes to FAULT on an illegal word, to DONE on halt, to ROT2 on a rotate, and to FETCH otherwise. ROT2 goes to ROT3, and ROT3 goes to FETCH.

Top module: `tiny_regcore`

## Requirements
- R1: After reset, busy, halted and err are 0, result is 0 and imem_addr is 0.
- R2: A start pulse while not busy clears all registers, the program counter, result and err. In the next cycle busy is 1 and imem_addr is 0.
- R3: The opcode is in bits 15:12. Opcode 0 (halt) copies register 0 to result, sets halted and clears busy. The program counter then stays at the halt address, and result and imem_addr stay fixed until the next start.
- R4: Opcode 1 (load) writes the zero-extended immediate in bits 7:0 into the register whose index is in bits 11:8.
- R5: Opcode 2 (rotate) uses a = bits 11:8, b = bits 7:4 and c = bits 3:0, and runs three steps in order: R[c] takes R[a], then R[a] takes R[b], then R[b] takes the new R[c]. Index aliasing follows from that order.
- R6: Opcode 3 (add) writes R[a] + R[b] into R[c], using the same fields as R5, wrapping modulo 2^16.
- R7: Opcode 4 (branch) sets the next program counter to the current one minus the offset in bits 11:0, modulo 2^IADDR_W. Every other non-halting instruction adds one.
- R8: An opcode of 5 to 15 sets err and halted, writes no register and leaves result unchanged. err stays set until the next start.
- R9: A register index of 3 or more, in a field that load, rotate or add uses, faults as in R8 without writing any register.
- R10: The core samples imem_rdata one cycle after it drives imem_addr. Each instruction is busy for 3 cycles (fetch, latch, execute), and a rotate for 5.
- R11: busy and halted are never 1 together, and a halted core stays halted until start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run from address 0 (ignored while busy) |
| imem_addr | output | IADDR_W | Instruction-memory read address (the program counter) |
| imem_rdata | input | 16 | Instruction word, valid one cycle after the address |
| busy | output | 1 | Core is running |
| halted | output | 1 | Core has stopped on halt or fault |
| err | output | 1 | Sticky fault flag |
| result | output | DATA_W | Register 0 as captured at halt |

## Verification
The hardest effects to observe are the ones that leave no direct trace at the ports. The final contents of R1 and R2 after a rotate are one example; a branch that lands ahead of itself through program-counter wrap is another. For the rotate, the bench adds extra load and add steps after it so that the old R[a] value moves through an adder into register 0, where the halt result exposes it. For the branch, a large offset wraps the counter forward past a halt word, and a second, backward branch then returns to that halt. The final result and the busy-cycle count prove that both jumps happened. Fault runs are each followed by a clean run, which shows that start clears the sticky flag.

// File: rtl/tiny_regcore_pkg.sv
package tiny_regcore_pkg;

    localparam int INSN_W = 16;
    localparam int IDX_W  = 4;

    localparam logic [3:0] OPC_HALT = 4'd0;
    localparam logic [3:0] OPC_LOAD = 4'd1;
    localparam logic [3:0] OPC_ROT  = 4'd2;
    localparam logic [3:0] OPC_ADD  = 4'd3;
    localparam logic [3:0] OPC_JMP  = 4'd4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LATCH,
        ST_EXEC,
        ST_ROT2,
        ST_ROT3,
        ST_DONE,
        ST_FAULT
    } state_e;

    typedef struct packed {
        logic [3:0]       op;
        logic [IDX_W-1:0] ra;
        logic [IDX_W-1:0] rb;
        logic [IDX_W-1:0] rc;
        logic [7:0]       imm;
        logic [11:0]      offs;
    } fields_t;

endpackage

// File: rtl/trc_decode.sv
module trc_decode
    import tiny_regcore_pkg::*;
#(
    parameter int NREG = 3
) (
    input  logic [INSN_W-1:0] ir,
    output fields_t           f,
    output logic              legal
);

    logic ra_ok, rb_ok, rc_ok;

    always_comb begin
        f.op   = ir[15:12];
        f.ra   = ir[11:8];
        f.rb   = ir[7:4];
        f.rc   = ir[3:0];
        f.imm  = ir[7:0];
        f.offs = ir[11:0];
        ra_ok  = int'(ir[11:8]) < NREG;
        rb_ok  = int'(ir[7:4])  < NREG;
        rc_ok  = int'(ir[3:0])  < NREG;
        unique case (ir[15:12])
            OPC_HALT: legal = 1'b1;
            OPC_LOAD: legal = ra_ok;
            OPC_ROT:  legal = ra_ok && rb_ok && rc_ok;
            OPC_ADD:  legal = ra_ok && rb_ok && rc_ok;
            OPC_JMP:  legal = 1'b1;
            default:  legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/trc_regfile.sv
module trc_regfile #(
    parameter int NREG = 3,
    parameter int DW   = 16,
    parameter int IW   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] ridx0,
    input  logic [IW-1:0] ridx1,
    output logic [DW-1:0] rdata0,
    output logic [DW-1:0] rdata1
);

    localparam int FLAT_W = NREG * DW;

    logic [FLAT_W-1:0] flat;

    generate
        for (genvar g = 0; g < NREG; g++) begin : gen_reg
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    q <= '0;
                end else if (we && (widx == IW'(g))) begin
                    q <= wdata;
                end
            end
            assign flat[g*DW +: DW] = q;
        end
    endgenerate

    always_comb begin
        rdata0 = '0;
        rdata1 = '0;
        for (int i = 0; i < NREG; i++) begin
            if (ridx0 == IW'(i)) rdata0 = flat[i*DW +: DW];
            if (ridx1 == IW'(i)) rdata1 = flat[i*DW +: DW];
        end
    end

endmodule

// File: rtl/trc_pcunit.sv
module trc_pcunit #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  logic          jump,
    input  logic [11:0]   offs,
    output logic [AW-1:0] pc
);

    logic [AW-1:0] offs_n;

    assign offs_n = AW'(offs);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pc <= '0;
        end else if (jump) begin
            pc <= pc - offs_n;
        end else if (step) begin
            pc <= pc + AW'(1);
        end
    end

endmodule

// File: rtl/tiny_regcore.sv
module tiny_regcore
    import tiny_regcore_pkg::*;
#(
    parameter int IADDR_W = 8,
    parameter int DATA_W  = 16,
    parameter int NREG    = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic [IADDR_W-1:0] imem_addr,
    input  logic [INSN_W-1:0]  imem_rdata,
    output logic               busy,
    output logic               halted,
    output logic               err,
    output logic [DATA_W-1:0]  result
);

    state_e              state, state_nx;
    logic [INSN_W-1:0]   ir;
    fields_t             f;
    logic                legal;
    logic                start_ok;
    logic                rf_we;
    logic [IDX_W-1:0]    rf_widx, rd0_idx;
    logic [DATA_W-1:0]   rf_wdata, rd0, rd1;
    logic                pc_step, pc_jump;
    logic [IADDR_W-1:0]  pc;
    logic [DATA_W-1:0]   res_q;
    logic                err_q;

    assign start_ok = start &&
        (state == ST_IDLE || state == ST_DONE || state == ST_FAULT);

    trc_decode #(.NREG(NREG)) u_dec (
        .ir    (ir),
        .f     (f),
        .legal (legal)
    );

    trc_regfile #(.NREG(NREG), .DW(DATA_W), .IW(IDX_W)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .clr    (start_ok),
        .we     (rf_we),
        .widx   (rf_widx),
        .wdata  (rf_wdata),
        .ridx0  (rd0_idx),
        .ridx1  (f.rb),
        .rdata0 (rd0),
        .rdata1 (rd1)
    );

    trc_pcunit #(.AW(IADDR_W)) u_pc (
        .clk  (clk),
        .rst  (rst),
        .clr  (start_ok),
        .step (pc_step),
        .jump (pc_jump),
        .offs (f.offs),
        .pc   (pc)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE, ST_DONE, ST_FAULT: if (start) state_nx = ST_FETCH;
            ST_FETCH: state_nx = ST_LATCH;
            ST_LATCH: state_nx = ST_EXEC;
            ST_EXEC: begin
                if (!legal)                state_nx = ST_FAULT;
                else if (f.op == OPC_HALT) state_nx = ST_DONE;
                else if (f.op == OPC_ROT)  state_nx = ST_ROT2;
                else                       state_nx = ST_FETCH;
            end
            ST_ROT2: state_nx = ST_ROT3;
            ST_ROT3: state_nx = ST_FETCH;
            default: state_nx = ST_IDLE;
        endcase
    end

    // instruction register: word arrives one cycle after the address
    always_ff @(posedge clk) begin
        if (rst)                    ir <= '0;
        else if (state == ST_LATCH) ir <= imem_rdata;
    end

    // datapath control
    always_comb begin
        rf_we    = 1'b0;
        rf_widx  = f.rc;
        rf_wdata = rd0;
        pc_step  = 1'b0;
        pc_jump  = 1'b0;
        if (state == ST_ROT3)       rd0_idx = f.rc;
        else if (f.op == OPC_HALT)  rd0_idx = '0;
        else                        rd0_idx = f.ra;
        unique case (state)
            ST_EXEC: begin
                if (legal) begin
                    unique case (f.op)
                        OPC_LOAD: begin
                            rf_we    = 1'b1;
                            rf_widx  = f.ra;
                            rf_wdata = DATA_W'(f.imm);
                            pc_step  = 1'b1;
                        end
                        OPC_ADD: begin
                            rf_we    = 1'b1;
                            rf_widx  = f.rc;
                            rf_wdata = rd0 + rd1;
                            pc_step  = 1'b1;
                        end
                        OPC_ROT: begin
                            rf_we    = 1'b1;
                            rf_widx  = f.rc;
                            rf_wdata = rd0;
                        end
                        OPC_JMP: pc_jump = 1'b1;
                        default: ;
                    endcase
                end
            end
            ST_ROT2: begin
                rf_we    = 1'b1;
                rf_widx  = f.ra;
                rf_wdata = rd1;
            end
            ST_ROT3: begin
                rf_we    = 1'b1;
                rf_widx  = f.rb;
                rf_wdata = rd0;
                pc_step  = 1'b1;
            end
            default: ;
        endcase
    end

    // result and fault capture
    always_ff @(posedge clk) begin
        if (rst || start_ok) begin
            res_q <= '0;
            err_q <= 1'b0;
        end else if (state == ST_EXEC) begin
            if (!legal)                err_q <= 1'b1;
            else if (f.op == OPC_HALT) res_q <= rd0;
        end
    end

    // outputs
    always_comb begin
        busy      = (state == ST_FETCH) || (state == ST_LATCH) ||
                    (state == ST_EXEC)  || (state == ST_ROT2)  ||
                    (state == ST_ROT3);
        halted    = (state == ST_DONE) || (state == ST_FAULT);
        err       = err_q;
        result    = res_q;
        imem_addr = pc;
    end

endmodule

// File: rtl/trc_checker.sv
module trc_checker
    import tiny_regcore_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          halted,
    input logic          err,
    input logic [DW-1:0] result,
    input logic [AW-1:0] imem_addr,
    input state_e        state,
    input logic          rf_we
);

    a_r11_busy_halted_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && halted));

    a_r11_halt_holds: assert property (@(posedge clk) disable iff (rst)
        (halted && !start) |=> (halted && $stable(result) && $stable(imem_addr)));

    a_r2_start_fetch0: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && imem_addr == '0));

    a_r8_err_means_halted: assert property (@(posedge clk) disable iff (rst)
        err |-> halted);

    a_r9_no_write_on_fault: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAULT && $past(state) == ST_EXEC) |-> !$past(rf_we));

    a_r10_fetch_then_latch: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH) |=> (state == ST_LATCH));

    a_r5_rot_pc_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ROT2 || state == ST_ROT3) |-> $stable(imem_addr));

endmodule

bind tiny_regcore trc_checker #(.AW(IADDR_W), .DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .halted    (halted),
    .err       (err),
    .result    (result),
    .imem_addr (imem_addr),
    .state     (state),
    .rf_we     (rf_we)
);

// File: tb/sim_tiny_regcore.sv
module sim_tiny_regcore;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int DW         = 16;
    localparam int DEPTH      = 1 << AW;

    typedef struct {
        logic [DW-1:0] res;
        logic          err;
        int            cyc;
        string         tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] imem_addr;
    logic [15:0]   imem_rdata = '0;
    logic          busy, halted, err;
    logic [DW-1:0] result;

    logic [15:0]   mem [DEPTH];
    item_t         sb[$];
    int            n_chk = 0;
    int            n_bad = 0;
    int            busy_cnt = 0;
    logic          halted_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // registered-read instruction memory
    always @(posedge clk) imem_rdata <= mem[imem_addr];

    tiny_regcore #(.IADDR_W(AW), .DATA_W(DW), .NREG(3)) u0 (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .busy       (busy),
        .halted     (halted),
        .err        (err),
        .result     (result)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wipe();
        for (int i = 0; i < DEPTH; i++) mem[i] = 16'h0000;
    endtask

    // driver: push expectation, pulse start, wait for stop
    task automatic launch(input logic [DW-1:0] res, input logic e,
                          input int cyc, input string tag);
        item_t it;
        it.res = res; it.err = e; it.cyc = cyc; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({"R2 first fetch busy (", tag, ")"}, busy, 1);
        check({"R2 first fetch addr (", tag, ")"}, imem_addr, 0);
        while (!halted) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor: count busy cycles, compare on halt
    always @(negedge clk) begin
        if (busy) busy_cnt++;
        if (halted && !halted_prev) begin
            if (sb.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R11 unexpected halt: actual 1 expected 0");
            end else begin
                item_t it;
                it = sb.pop_front();
                check({"result (", it.tag, ")"}, result, it.res);
                check({"R8 err (", it.tag, ")"}, err, it.err);
                check({"R10 busy cycles (", it.tag, ")"}, busy_cnt, it.cyc);
            end
            busy_cnt = 0;
        end
        halted_prev = halted;
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wipe();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 halted", halted, 0);
        check("R1 err", err, 0);
        check("R1 result", result, 0);
        check("R1 imem_addr", imem_addr, 0);

        // R3 R4 R5 R6: aliasing rotate program
        wipe();
        mem[0] = 16'h1110; mem[1] = 16'h2100; mem[2] = 16'h3010; mem[3] = 16'h0000;
        launch(16'h0020, 1'b0, 14, "R3 R4 R5 R6 base");
        // R11 R3: halted state holds, fetch stopped at halt address
        repeat (10) @(negedge clk);
        check("R11 still halted", halted, 1);
        check("R11 not busy", busy, 0);
        check("R3 result held", result, 16'h0020);
        check("R3 pc at halt addr", imem_addr, 3);

        // R4 zero-extended immediate
        wipe();
        mem[0] = 16'h10FF; mem[1] = 16'h0000;
        launch(16'h00FF, 1'b0, 6, "R4 zext");

        // R2 start clears registers
        wipe();
        launch(16'h0000, 1'b0, 3, "R2 clear");

        // R6 add wrap: nine doublings of 0xFF
        wipe();
        mem[0] = 16'h10FF;
        for (int i = 1; i <= 9; i++) mem[i] = 16'h3000;
        mem[10] = 16'h0000;
        launch(16'hFE00, 1'b0, 33, "R6 wrap");

        // R5 rotate distinct indices
        wipe();
        mem[0] = 16'h1001; mem[1] = 16'h1102; mem[2] = 16'h1203;
        mem[3] = 16'h2012; mem[4] = 16'h0000;
        launch(16'h0002, 1'b0, 17, "R5 R[a] gets old R[b]");
        mem[4] = 16'h1200; mem[5] = 16'h3120; mem[6] = 16'h0000;
        launch(16'h0001, 1'b0, 23, "R5 R[b] gets old R[a]");
        mem[4] = 16'h1100; mem[5] = 16'h3210; mem[6] = 16'h0000;
        launch(16'h0001, 1'b0, 23, "R5 R[c] gets old R[a]");

        // R7 branch: wrap forward then backward
        wipe();
        mem[0] = 16'h1001; mem[1] = 16'h4FFE; mem[2] = 16'h0000;
        mem[3] = 16'h3000; mem[4] = 16'h4002;
        launch(16'h0002, 1'b0, 15, "R7 branch");
        check("R7 pc at halt addr", imem_addr, 2);

        // R8 undefined opcodes
        wipe();
        mem[0] = 16'h1007; mem[1] = 16'h5000;
        launch(16'h0000, 1'b1, 6, "R8 opcode 5");
        repeat (5) @(negedge clk);
        check("R8 err sticky", err, 1);
        check("R8 halted", halted, 1);
        wipe();
        mem[0] = 16'hF0FF;
        launch(16'h0000, 1'b1, 3, "R8 opcode 15");

        // start clears err
        wipe();
        mem[0] = 16'h1110; mem[1] = 16'h2100; mem[2] = 16'h3010; mem[3] = 16'h0000;
        launch(16'h0020, 1'b0, 14, "R8 err cleared by start");

        // R9 bad register index
        wipe();
        mem[0] = 16'h1307;
        launch(16'h0000, 1'b1, 3, "R9 load idx3");
        wipe();
        mem[0] = 16'h1001; mem[1] = 16'h3013;
        launch(16'h0000, 1'b1, 6, "R9 add idx3");
        wipe();
        mem[0] = 16'h2310;
        launch(16'h0000, 1'b1, 3, "R9 rotate idx3");

        check("R11 scoreboard drained", sb.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule